// File: doc/BRIEF.md
# Multi-Pin Input Debounce Filter

This block removes short glitches from a group of general-purpose input pins before the rest of the chip sees them. All pins share one sampling tick. The tick comes from the system clock through a prescaler, and a two-bit field picks the division. For a pin whose filter is enabled, a new level reaches the output only after it has been sampled unchanged on three consecutive ticks. Any shorter excursion is thrown away.

A pin whose enable bit is clear passes its synchronised input straight to the output. The same bypass applies to every pin while the stop-mode input is high. When stop mode ends, each pin returns to the behaviour its enable bit selects. Before any filtering or bypass, the raw inputs pass through a two-flop synchroniser.

Top module: `pin_debounce_filter`

## Requirements
- R1: Reset (rst_n low) clears the control-related state, the candidate levels and the filtered levels to 0. With a control byte of 0x00 and all inputs low, every output reads 0 after reset.
- R2: Control bits [7:6] select the sampling period. Code 00 gives a tick on every clock, code 01 every DIV_MID clocks (default 4), and code 10 every DIV_SLOW clocks (default 4096).
- R3: With code 11, no sampling tick occurs. The filtered level of every enabled pin then stays frozen, whatever the pin does.
- R4: Control bit i (for i in 0..5) set to 0 bypasses the filter for pin i. The output then follows the raw input exactly two clocks later.
- R5: On an enabled pin, a level seen on only one or two consecutive ticks never reaches the output.
- R6: On an enabled pin, a level held for three ticks reaches the output. With code 00 the output changes on the fifth clock edge after the input changes, which is two synchroniser clocks plus three ticks.
- R7: While stop_mode is 1, every output follows its synchronised input two clocks late. When stop_mode returns to 0, enabled pins show their filtered level again.
- R8: A change of the select field restarts the prescaler. With code 01 selected on the same edge as an input change, the filtered output changes on the 13th clock edge, after ticks on edges 5, 9 and 13. With code 10 the ticks fall on edges 65, 129 and 193 when DIV_SLOW is 64.
- R9: Pins are filtered independently. A glitch on one pin does not affect another pin's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl | input | 8 | [7:6] sample select, [5:0] per-pin filter enable |
| stop_mode | input | 1 | High forces bypass on all pins |
| pin_raw | input | 6 | Raw asynchronous pin levels |
| pin_out | output | 6 | Debounced pin levels |

## Verification
The bench keeps DIV_MID at 4 but builds the block with DIV_SLOW set to 64. With that setting, the slow-code restart timing can be checked at its exact edge: the accepting tick lands on clock 193. The middle code keeps windows of 4 and 8 clocks, which span exactly one and two ticks whatever the phase, so rejection at that code can be tested without knowing the phase. Code 00 gives exact edge counts for acceptance, synchroniser delay and bypass.

// File: rtl/dbf_pkg.sv
package dbf_pkg;

  typedef enum logic [1:0] {
    SMP_EVERY = 2'd0,
    SMP_MID   = 2'd1,
    SMP_SLOW  = 2'd2,
    SMP_HOLD  = 2'd3
  } smp_sel_e;

  // number of identical samples needed before a level is accepted
  localparam int unsigned ACCEPT_RUN = 3;

  function automatic int unsigned sel_period(input logic [1:0] sel,
                                             input int unsigned mid,
                                             input int unsigned slow);
    case (sel)
      SMP_MID:  return mid;
      SMP_SLOW: return slow;
      default:  return 1;
    endcase
  endfunction

  // saturating run counter step
  function automatic logic [1:0] run_step(input logic [1:0] run);
    return (run == 2'(ACCEPT_RUN)) ? run : run + 2'd1;
  endfunction

endpackage

// File: rtl/dbf_sync2.sv
module dbf_sync2 #(
  parameter int WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/dbf_tick_gen.sv
module dbf_tick_gen #(
  parameter int unsigned DIV_MID  = 4,
  parameter int unsigned DIV_SLOW = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  output logic       tick,
  output logic       sel_change
);
  import dbf_pkg::*;

  localparam int CNT_W = (DIV_SLOW > 2) ? $clog2(DIV_SLOW) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic [1:0]       sel_q;
  logic             hold;
  logic             at_limit;

  assign limit      = CNT_W'(sel_period(sel, DIV_MID, DIV_SLOW) - 1);
  assign sel_change = (sel != sel_q);
  assign hold       = (sel == SMP_HOLD);
  assign at_limit   = (cnt_q == limit);
  assign tick       = !sel_change && !hold && at_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sel_q <= SMP_EVERY;
    end else begin
      sel_q <= sel;
      if (sel_change || hold || at_limit) cnt_q <= '0;
      else                                cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SMP_HOLD) |-> !tick); // R3
  AST_EVERY_CLOCK_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SMP_EVERY && sel_q == SMP_EVERY) |-> tick); // R2
  AST_RESTART_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    sel_change |=> (cnt_q == '0)); // R8
endmodule

// File: rtl/dbf_pin_filter.sv
module dbf_pin_filter (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic smp,
  output logic filt
);
  import dbf_pkg::*;

  logic       cand_q;
  logic       filt_q;
  logic [1:0] run_q;
  logic       differs;
  logic       accept;

  assign differs = (smp != cand_q);
  assign accept  = tick && !differs && (run_q == 2'(ACCEPT_RUN - 1));
  assign filt    = filt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q <= 1'b0;
      filt_q <= 1'b0;
      run_q  <= 2'd0;
    end else if (tick) begin
      if (differs) begin
        cand_q <= smp;
        run_q  <= 2'd1;
      end else begin
        run_q <= run_step(run_q);
      end
      if (accept) filt_q <= cand_q;
    end
  end

  AST_FROZEN_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(filt_q)); // R3
  AST_UPDATE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt_q) |-> (run_q == 2'(ACCEPT_RUN))); // R6
endmodule

// File: rtl/pin_debounce_filter.sv
module pin_debounce_filter #(
  parameter int          NUM_PINS = 6,
  parameter int unsigned DIV_MID  = 4,
  parameter int unsigned DIV_SLOW = 4096
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PINS+1:0]   ctrl,
  input  logic                  stop_mode,
  input  logic [NUM_PINS-1:0]   pin_raw,
  output logic [NUM_PINS-1:0]   pin_out
);
  localparam int SEL_LO = NUM_PINS;

  logic [1:0]          smp_sel;
  logic [NUM_PINS-1:0] pin_en;
  logic [NUM_PINS-1:0] pin_sync;
  logic [NUM_PINS-1:0] pin_filt;
  logic                smp_tick;
  logic                sel_change;

  assign smp_sel = ctrl[SEL_LO+1:SEL_LO];
  assign pin_en  = ctrl[NUM_PINS-1:0];

  dbf_sync2 #(.WIDTH(NUM_PINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_raw),
    .q     (pin_sync)
  );

  dbf_tick_gen #(.DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)) u_tick (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (smp_sel),
    .tick       (smp_tick),
    .sel_change (sel_change)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    dbf_pin_filter u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (smp_tick),
      .smp   (pin_sync[i]),
      .filt  (pin_filt[i])
    );
    assign pin_out[i] = (stop_mode || !pin_en[i]) ? pin_sync[i] : pin_filt[i];
  end

  AST_NO_TICK_ON_RESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    sel_change |-> !smp_tick); // R8
endmodule

// File: tb/pin_debounce_filter_test.sv
module pin_debounce_filter_test;
  localparam int NP = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    ctrl = 8'h00;
  logic          stop_mode = 1'b0;
  logic [NP-1:0] pin_raw = '0;
  logic [NP-1:0] pin_out;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pin_debounce_filter #(.NUM_PINS(NP), .DIV_MID(4), .DIV_SLOW(64)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl      (ctrl),
    .stop_mode (stop_mode),
    .pin_raw   (pin_raw),
    .pin_out   (pin_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle_low(input logic [7:0] c);
    ctrl = 8'h3F; stop_mode = 1'b0; pin_raw = '0;
    step(8);
    ctrl = c;
    step(2);
  endtask

  task automatic t_reset;
    chk(pin_out == '0, "R1 outputs after reset", pin_out, 0);
  endtask

  task automatic t_bypass;
    settle_low(8'h00);
    pin_raw[4] = 1'b1;
    step(1);
    chk(pin_out[4] == 1'b0, "R4 bypass one clock", pin_out[4], 0);
    step(1);
    chk(pin_out[4] == 1'b1, "R4 bypass two clocks", pin_out[4], 1);
  endtask

  task automatic t_fast_pass;
    settle_low(8'h3F);
    pin_raw[0] = 1'b1;
    step(4);
    chk(pin_out[0] == 1'b0, "R6 before fifth edge", pin_out[0], 0);
    step(1);
    chk(pin_out[0] == 1'b1, "R6 at fifth edge", pin_out[0], 1);
  endtask

  task automatic t_fast_glitch(input int len);
    bit kept = 1'b1;
    pin_raw[0] = 1'b0;
    step(len);
    pin_raw[0] = 1'b1;
    for (int k = 0; k < 12; k++) begin
      step(1);
      if (pin_out[0] != 1'b1) kept = 1'b0;
    end
    chk(kept, $sformatf("R5 fast glitch of %0d ticks", len), kept, 1);
  endtask

  task automatic t_mid_exact;
    settle_low(8'h3F);
    ctrl = 8'h7F;
    pin_raw[1] = 1'b1;
    step(12);
    chk(pin_out[1] == 1'b0, "R8 mid before edge 13", pin_out[1], 0);
    step(1);
    chk(pin_out[1] == 1'b1, "R8 mid at edge 13", pin_out[1], 1);
  endtask

  task automatic t_mid_glitch;
    bit kept = 1'b1;
    bit seen = 1'b0;
    for (int len = 4; len <= 8; len += 4) begin
      pin_raw[1] = 1'b0;
      step(len);
      pin_raw[1] = 1'b1;
      for (int k = 0; k < 24; k++) begin
        step(1);
        if (pin_out[1] != 1'b1) kept = 1'b0;
      end
    end
    chk(kept, "R5 mid glitches of 1 and 2 ticks", kept, 1);
    pin_raw[1] = 1'b0;
    step(12);
    pin_raw[1] = 1'b1;
    for (int k = 0; k < 24; k++) begin
      step(1);
      if (pin_out[1] == 1'b0) seen = 1'b1;
    end
    chk(seen, "R6 mid pulse of 3 ticks passes", seen, 1);
  endtask

  task automatic t_slow_exact;
    settle_low(8'h3F);
    ctrl = 8'hBF;
    pin_raw[2] = 1'b1;
    step(192);
    chk(pin_out[2] == 1'b0, "R8 slow before edge 193", pin_out[2], 0);
    step(1);
    chk(pin_out[2] == 1'b1, "R2 R8 slow at edge 193", pin_out[2], 1);
  endtask

  task automatic t_hold_and_stop;
    settle_low(8'hFF);
    pin_raw[3] = 1'b1;
    step(60);
    chk(pin_out[3] == 1'b0, "R3 reserved code freezes", pin_out[3], 0);
    stop_mode = 1'b1;
    step(1);
    chk(pin_out[3] == 1'b1, "R7 stop bypass shows input", pin_out[3], 1);
    pin_raw[3] = 1'b0;
    step(1);
    chk(pin_out[3] == 1'b1, "R7 stop one clock", pin_out[3], 1);
    step(1);
    chk(pin_out[3] == 1'b0, "R7 stop two clocks", pin_out[3], 0);
    pin_raw[3] = 1'b1;
    step(3);
    stop_mode = 1'b0;
    step(1);
    chk(pin_out[3] == 1'b0, "R7 filtered level after stop", pin_out[3], 0);
    ctrl = 8'h3F;
    step(6);
    chk(pin_out[3] == 1'b1, "R2 code 00 resumes sampling", pin_out[3], 1);
  endtask

  task automatic t_independent;
    bit clean = 1'b1;
    settle_low(8'h01);
    pin_raw[0] = 1'b1;
    pin_raw[5] = 1'b1;
    step(1);
    pin_raw[0] = 1'b0;
    pin_raw[5] = 1'b0;
    step(1);
    chk(pin_out[5] == 1'b1, "R9 bypassed pin shows pulse", pin_out[5], 1);
    for (int k = 0; k < 8; k++) begin
      step(1);
      if (pin_out[0] != 1'b0) clean = 1'b0;
    end
    chk(clean, "R9 filtered pin keeps low", clean, 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_bypass();
    t_fast_pass();
    t_fast_glitch(1);
    t_fast_glitch(2);
    t_mid_exact();
    t_mid_glitch();
    t_slow_exact();
    t_hold_and_stop();
    t_independent();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule